// File: doc/BRIEF.md
# Oversampling UART Receive Deserializer

This block turns an asynchronous serial line into parallel words. A free-running sample tick, supplied from outside at sixteen times the bit rate, paces the whole receiver. The line first passes through a two-flop synchronizer. While the receiver is idle, the first tick that sees the synchronized line low is counted as tick 1 of a start bit. From then on every bit lasts sixteen ticks. The level of each bit is settled by a two-out-of-three vote over the samples on ticks 7, 8 and 9.

Data bits arrive least significant bit first and are shifted into a receive shift register. Each frame carries eight or nine data bits, and the mode is taken at the moment the start bit is detected. After the vote on the stop bit, the finished word is presented for one clock cycle with a valid pulse, together with a framing-error flag when the stop bit was voted low. The receiver is idle again at once and can catch the next start bit on the very next tick. A downstream buffer consumes the pulse. Driving the enable low holds the receive logic in its cleared idle state.

Top module: `ovs_uart_rx`

## Requirements
- R1: While reset is asserted and after reset is released, wordValid, wordData, wordBit8 and wordFrameErr are all 0.
- R2: While rxEnable is low no word is produced. Dropping rxEnable in the middle of a frame discards that frame, and a later clean frame is received correctly.
- R3: rxLine passes through a two-flop synchronizer. In idle, the first tick on which the synchronized line is low is tick 1 of the start bit. Every following bit spans 16 ticks.
- R4: If the vote over the start bit's ticks 7, 8 and 9 is high, the start is treated as a glitch and the receiver returns to idle without producing a word.
- R5: Each bit level is the 2-of-3 majority of the line samples on ticks 7, 8 and 9 of that bit. A single disagreeing sample does not change the bit, and two disagreeing samples do.
- R6: Data bits are received LSB first. In 8-bit mode (nineBitMode = 0), wordData[i] is the i-th received data bit and wordBit8 is 0.
- R7: In 9-bit mode (nineBitMode = 1), nine data bits are received. The ninth bit, which follows data bit 7, appears on wordBit8.
- R8: nineBitMode is sampled only on the tick that detects a start bit. A change during the frame does not affect that frame.
- R9: The word is handed off on tick 9 of the stop bit. wordValid is high for exactly the one clock cycle after the edge that processes tick number 16*(N+1)+9, counted from the start tick as 1, where N is the number of data bits. The outputs hold until the next word.
- R10: wordFrameErr is 1 when the stop bit votes low and 0 otherwise. The word is delivered in both cases.
- R11: After the stop bit's tick 9 the receiver is idle. A line low on the stop bit's tick 10 is detected as the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receive enable; low clears and holds the receive logic |
| sampleTick | input | 1 | One-cycle tick at 16x the bit rate |
| nineBitMode | input | 1 | 1 selects nine data bits, 0 selects eight |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| wordValid | output | 1 | One-cycle pulse when a word is handed off |
| wordData | output | DATA_W | Low eight data bits of the last word |
| wordBit8 | output | 1 | Ninth data bit of the last word (0 in 8-bit mode) |
| wordFrameErr | output | 1 | Stop bit of the last word was voted low |

## Verification
Two timing points govern every word check. The bench changes rxLine one nanosecond after a tick edge, so the two synchronizer stages settle well inside the four-clock tick spacing. The word result is due right after the edge of tick 16*(N+1)+9, counted from the first tick that sees the line low. At one nanosecond past that edge the bench requires wordValid high and the pulse counter still unchanged, which shows that nothing arrived early. One clock later it requires wordValid low again, with exactly one pulse counted. For glitch, disable and enable-drop cases, the same pulse counter must stay flat over a window longer than a whole frame.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;    // drop samples and partial word
    logic takeSample;  // store line level (ticks 7 and 8)
    logic shiftBit;    // shift voted bit into the word (tick 9 of a data bit)
    logic emitWord;    // hand off word (tick 9 of stop bit)
    logic nineBits;    // frame carries nine data bits
  } rxStrobes_t;

endpackage

// File: rtl/ovs_rx_ctrl.sv
module ovs_rx_ctrl
  import ovs_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       sampleTick,
  input  logic       nineBitMode,
  input  logic       lineSync,
  input  logic       voteBit,
  output rxStrobes_t strobes
);

  localparam int SR_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(OVS + 1);
  localparam int IDX_W = $clog2(SR_W);
  localparam logic [CNT_W-1:0] TICK_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] TICK_A    = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] TICK_B    = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] TICK_C    = CNT_W'(OVS / 2 + 1);
  localparam logic [IDX_W-1:0] IDX_NINE  = IDX_W'(SR_W - 1);
  localparam logic [IDX_W-1:0] IDX_EIGHT = IDX_W'(SR_W - 2);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             nineQ;
  logic             busy;
  logic             bitWrap;
  logic             atA, atB, atC;

  always_comb begin
    busy    = (state != RX_IDLE);
    bitWrap = (cnt == TICK_LAST);
    cntNext = bitWrap ? TICK_ONE : cnt + TICK_ONE;
    atA     = (cntNext == TICK_A);
    atB     = (cntNext == TICK_B);
    atC     = (cntNext == TICK_C);
    lastIdx = nineQ ? IDX_NINE : IDX_EIGHT;
  end

  always_comb begin
    strobes.clearAll   = !rxEnable || !busy;
    strobes.takeSample = rxEnable && busy && sampleTick && (atA || atB);
    strobes.shiftBit   = rxEnable && (state == RX_DATA) && sampleTick && atC;
    strobes.emitWord   = rxEnable && (state == RX_STOP) && sampleTick && atC;
    strobes.nineBits   = nineQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      nineQ  <= 1'b0;
    end else if (!rxEnable) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (sampleTick) begin
      unique case (state)
        RX_IDLE: begin
          if (!lineSync) begin
            state  <= RX_START;
            cnt    <= TICK_ONE;
            bitIdx <= '0;
            nineQ  <= nineBitMode;
          end
        end
        RX_START: begin
          cnt <= cntNext;
          if (atC && voteBit) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end else if (bitWrap) begin
            state  <= RX_DATA;
            bitIdx <= '0;
          end
        end
        RX_DATA: begin
          cnt <= cntNext;
          if (bitWrap) begin
            if (bitIdx == lastIdx) state <= RX_STOP;
            else                   bitIdx <= bitIdx + IDX_W'(1);
          end
        end
        RX_STOP: begin
          cnt <= cntNext;
          if (atC) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R2: a low enable forces idle on the next edge
  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == RX_IDLE));

  // R3: leaving idle needs a tick that saw the synchronized line low
  assert_start_on_low_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy)) |-> $past(sampleTick && !lineSync && rxEnable));

  // R5: tick position stays inside one bit period while a frame is active
  assert_tick_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt >= TICK_ONE && cnt <= TICK_LAST));

  // R7: data bit index never passes the last bit of the latched mode
  assert_bit_index_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_DATA) |-> (bitIdx <= lastIdx));

endmodule

// File: rtl/ovs_rx_dpath.sv
module ovs_rx_dpath
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobes_t        strobes,
  output logic              lineSync,
  output logic              voteBit,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic              wordBit8,
  output logic              wordFrameErr
);

  localparam int SR_W = DATA_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [1:0]             sampQ;
  logic [SR_W-1:0]        shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end

  assign lineSync = syncQ[SYNC_STAGES-1];

  // two stored samples plus the live third one
  assign voteBit = (sampQ[0] & sampQ[1]) | (sampQ[0] & lineSync) | (sampQ[1] & lineSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sampQ <= '0;
    else if (strobes.clearAll)   sampQ <= '0;
    else if (strobes.takeSample) sampQ <= {sampQ[0], lineSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftQ <= '0;
    else if (strobes.clearAll) shiftQ <= '0;
    else if (strobes.shiftBit) shiftQ <= {voteBit, shiftQ[SR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid    <= 1'b0;
      wordData     <= '0;
      wordBit8     <= 1'b0;
      wordFrameErr <= 1'b0;
    end else begin
      wordValid <= strobes.emitWord;
      if (strobes.emitWord) begin
        wordData     <= strobes.nineBits ? shiftQ[DATA_W-1:0] : shiftQ[SR_W-1:1];
        wordBit8     <= strobes.nineBits & shiftQ[SR_W-1];
        wordFrameErr <= !voteBit;
      end
    end
  end

  // R9: handoff is a single-cycle pulse
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              sampleTick,
  input  logic              nineBitMode,
  input  logic              rxLine,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic              wordBit8,
  output logic              wordFrameErr
);

  rxStrobes_t strobes;
  logic       lineSync;
  logic       voteBit;

  ovs_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .sampleTick (sampleTick),
    .nineBitMode(nineBitMode),
    .lineSync   (lineSync),
    .voteBit    (voteBit),
    .strobes    (strobes)
  );

  ovs_rx_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .strobes     (strobes),
    .lineSync    (lineSync),
    .voteBit     (voteBit),
    .wordValid   (wordValid),
    .wordData    (wordData),
    .wordBit8    (wordBit8),
    .wordFrameErr(wordFrameErr)
  );

endmodule

// File: tb/tb_ovs_uart_rx.sv
`timescale 1ns/1ps
module tb_ovs_uart_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic       sampleTick = 1'b0;
  logic       nineBitMode = 1'b0;
  logic       rxLine = 1'b1;
  logic       wordValid;
  logic [7:0] wordData;
  logic       wordBit8;
  logic       wordFrameErr;

  int checks = 0;
  int fails = 0;
  int validCount = 0;
  logic [1:0] div = 2'd0;

  ovs_uart_rx dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .sampleTick(sampleTick),
    .nineBitMode(nineBitMode), .rxLine(rxLine), .wordValid(wordValid),
    .wordData(wordData), .wordBit8(wordBit8), .wordFrameErr(wordFrameErr)
  );

  always #10 clk = ~clk;  // 50 MHz

  // tick every fourth clock, changed away from the active edge
  always @(negedge clk) begin
    div        <= div + 2'd1;
    sampleTick <= (div == 2'd3);
  end

  always @(posedge clk) if (wordValid) validCount <= validCount + 1;

  // {nine, payload[8:0], stopLow, glitchBit[3:0], glitchMask[2:0], expData[7:0], expBit8, expFerr}
  localparam logic [27:0] VEC [0:7] = '{
    {1'b0, 9'h0A5, 1'b0, 4'hF, 3'b000, 8'hA5, 1'b0, 1'b0},
    {1'b0, 9'h03C, 1'b1, 4'hF, 3'b000, 8'h3C, 1'b0, 1'b1},
    {1'b1, 9'h15A, 1'b0, 4'hF, 3'b000, 8'h5A, 1'b1, 1'b0},
    {1'b1, 9'h0FF, 1'b1, 4'hF, 3'b000, 8'hFF, 1'b0, 1'b1},
    {1'b0, 9'h000, 1'b0, 4'h3, 3'b010, 8'h00, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 4'h3, 3'b011, 8'h08, 1'b0, 1'b0},
    {1'b0, 9'h0FF, 1'b0, 4'h0, 3'b101, 8'hFE, 1'b0, 1'b0},
    {1'b1, 9'h100, 1'b0, 4'h8, 3'b001, 8'h00, 1'b1, 1'b0}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(posedge clk); while (!sampleTick);
  endtask

  // drives start, data and stop up to and including stop tick 9
  task automatic driveFrame(input int nBits, input logic [8:0] pay, input logic stopLow,
                            input int gBit, input logic [2:0] gMask, input bit aligned);
    if (!aligned) waitTick();
    for (int b = 0; b <= nBits + 1; b++) begin
      logic lvl;
      if (b == 0)              lvl = 1'b0;
      else if (b == nBits + 1) lvl = !stopLow;
      else                     lvl = pay[b-1];
      for (int j = 1; j <= 16; j++) begin
        if (b == nBits + 1 && j > 9) break;
        #1;
        if ((b - 1) == gBit && j >= 7 && j <= 9) rxLine = lvl ^ gMask[j-7];
        else                                      rxLine = lvl;
        waitTick();
      end
    end
  endtask

  task automatic finishStop();
    #1 rxLine = 1'b1;
    repeat (7) waitTick();
  endtask

  task automatic checkWord(input string tag, input int c0, input logic [7:0] eData,
                           input logic eB8, input logic eFerr);
    #1;
    check({tag, " R9 R3 valid due on stop tick 9"}, wordValid, 1'b1);
    check({tag, " R9 no earlier pulse"}, validCount, c0);
    check({tag, " R5 R6 data"}, wordData, eData);
    check({tag, " R7 bit8"}, wordBit8, eB8);
    check({tag, " R10 frame error"}, wordFrameErr, eFerr);
    @(posedge clk);
    #1;
    check({tag, " R9 single-cycle pulse"}, wordValid, 1'b0);
    check({tag, " R9 one pulse counted"}, validCount, c0 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", wordValid, 1'b0);
    check("R1 data in reset", wordData, 8'h00);
    rstN = 1'b1;
    rxEnable = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    check("R1 valid after reset", wordValid, 1'b0);
    check("R1 flags after reset", {wordBit8, wordFrameErr}, 2'b00);

    // vector table: modes, framing, majority vote
    for (int v = 0; v < 8; v++) begin
      nineBitMode = VEC[v][27];
      c0 = validCount;
      driveFrame(VEC[v][27] ? 9 : 8, VEC[v][26:18], VEC[v][17],
                 int'(VEC[v][16:13]), VEC[v][12:10], 1'b0);
      checkWord($sformatf("vec%0d", v), c0, VEC[v][9:2], VEC[v][1], VEC[v][0]);
      finishStop();
    end

    // R4: glitch start
    nineBitMode = 1'b0;
    c0 = validCount;
    waitTick();
    #1 rxLine = 1'b0;
    repeat (5) waitTick();
    #1 rxLine = 1'b1;
    repeat (200) waitTick();
    check("R4 glitch start gives no word", validCount, c0);
    driveFrame(8, 9'h096, 1'b0, 15, 3'b000, 1'b0);
    checkWord("R4 recovery", c0, 8'h96, 1'b0, 1'b0);
    finishStop();

    // R2: disabled receiver ignores a frame
    rxEnable = 1'b0;
    c0 = validCount;
    driveFrame(8, 9'h055, 1'b0, 15, 3'b000, 1'b0);
    finishStop();
    repeat (20) waitTick();
    check("R2 no word while disabled", validCount, c0);
    rxEnable = 1'b1;

    // R2: enable dropped mid-frame
    waitTick();
    #1 rxLine = 1'b0;
    repeat (30) waitTick();
    #1 rxEnable = 1'b0;
    repeat (3) @(posedge clk);
    #1 rxLine = 1'b1;
    rxEnable = 1'b1;
    repeat (200) waitTick();
    check("R2 dropped frame gives no word", validCount, c0);
    driveFrame(8, 9'h0C3, 1'b0, 15, 3'b000, 1'b0);
    checkWord("R2 after re-enable", c0, 8'hC3, 1'b0, 1'b0);
    finishStop();

    // R8: mode latched at start detection
    nineBitMode = 1'b1;
    c0 = validCount;
    fork
      driveFrame(9, 9'h133, 1'b0, 15, 3'b000, 1'b0);
      begin
        repeat (40) waitTick();
        #1 nineBitMode = 1'b0;
      end
    join
    checkWord("R8 mode change mid-frame", c0, 8'h33, 1'b1, 1'b0);
    finishStop();

    // R11: next start on stop tick 10
    nineBitMode = 1'b0;
    c0 = validCount;
    driveFrame(8, 9'h081, 1'b0, 15, 3'b000, 1'b0);
    checkWord("R11 first word", c0, 8'h81, 1'b0, 1'b0);
    driveFrame(8, 9'h07E, 1'b0, 15, 3'b000, 1'b1);
    checkWord("R11 back-to-back word", c0 + 1, 8'h7E, 1'b0, 1'b0);
    finishStop();
    repeat (4) waitTick();
    #1;
    check("R9 outputs held after word", wordData, 8'h7E);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule